// File: doc/BRIEF.md
# Fixed-Latency Flash Fetch Bridge

This block sits between a 16-bit processor fetch port and a 32-bit flash read port. The processor raises a read enable with a word address and waits for an acknowledge. The flash port takes a one-cycle read strobe and returns a 32-bit word a fixed number of cycles later, marked by a valid flag. The bridge checks whether the address falls inside the ROM window. If it does, the bridge sends exactly one read strobe to flash, with the word offset halved to form the flash address.

The bridge has no handshake state machine. The issued strobe, together with the low bit of the processor address, moves through a shift register as deep as the flash latency. The output of that shift register is the processor acknowledge. In the same cycle, the stored bit picks which half of the returning 32-bit word goes onto the 16-bit data bus. A new request can start while earlier ones are still in flight, because each one moves through the delay line on its own. Addresses outside the window produce no strobe and no acknowledge.

Top module: `flash_fetch_bridge`

## Requirements
- R1: A flash read strobe (`fl_read`) is produced only in a cycle where `cpu_rd_en` is high and `cpu_addr` lies in the window `ROM_BASE <= cpu_addr < ROM_BASE + ROM_WORDS` (default base 0x4000, 8192 words, i.e. 16 KB).
- R2: One strobe of exactly one cycle is issued per rising edge of the gated request (read enable AND in-window). Holding the read enable high, even while the address moves inside the window, issues no further strobe.
- R3: In a strobe cycle, `fl_addr` equals `(cpu_addr - ROM_BASE) >> 1`.
- R4: `cpu_ack` is high for exactly one cycle, `FLASH_LAT` (default 5) cycles after the cycle in which the strobe was issued. That is the cycle in which the flash reports valid data.
- R5: In an acknowledge cycle, `cpu_rdata` is bits [31:16] of `fl_rdata` when the window offset of the request was even, and bits [15:0] when it was odd.
- R6: Requests issued in successive gated edges while earlier ones are in flight are each acknowledged in order, each exactly `FLASH_LAT` cycles after its own strobe.
- R7: A read to an address outside the window gives no strobe and no acknowledge.
- R8: After a synchronous active-low reset, `cpu_ack` and `fl_read` are low and no acknowledge is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd_en | input | 1 | Processor read enable |
| cpu_addr | input | CPU_AW (23) | Processor word address |
| cpu_rdata | output | 16 | Read data to processor, valid with `cpu_ack` |
| cpu_ack | output | 1 | Data acknowledge to processor |
| fl_read | output | 1 | One-cycle read strobe to flash |
| fl_addr | output | FL_AW (12) | Flash 32-bit word address |
| fl_rdata | input | 32 | Flash read data |
| fl_rvalid | input | 1 | Flash read data valid |

## Verification
The bench targets the window edges: the last word below the base, the base itself, the last word inside and the first word past the end. A decoder that is off by one would issue a strobe or an acknowledge at the wrong edge. Holding the read enable high while the address wanders inside the window exposes a level-triggered design, which would issue a stream of strobes instead of one. Requests spaced two cycles apart keep several entries in flight at once, which catches a delay line that drops or merges pulses. Even and odd offsets catch swapped halves, and an acknowledge one cycle early or late shows up against the flash valid flag and as wrong data, because the flash model returns garbage outside its valid cycle.

// File: rtl/flash_bridge_pkg.sv
// Shared helpers for the flash fetch bridge.
// Assumes a 32-bit flash word holding two 16-bit processor words, even offset high.
package flash_bridge_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    // Pick one 16-bit half of a flash word from the odd/even offset bit.
    function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] word,
                                                   input logic odd);
        return odd ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    endfunction

endpackage

// File: rtl/rom_window_decode.sv
// Decides whether a processor word address lies in the ROM window and
// derives the flash word address and half-select bit from the offset.
// Assumes ROM_BASE is even so that the offset parity matches the address parity.
module rom_window_decode #(
    parameter int CPU_AW    = 23,
    parameter int ROM_BASE  = 'h4000,
    parameter int ROM_WORDS = 8192,
    parameter int FL_AW     = 12
) (
    input  logic [CPU_AW-1:0] addr,
    output logic              in_win,
    output logic [FL_AW-1:0]  word_addr,
    output logic              odd
);
    localparam logic [CPU_AW:0] LO = (CPU_AW+1)'(ROM_BASE);
    localparam logic [CPU_AW:0] HI = (CPU_AW+1)'(ROM_BASE + ROM_WORDS);

    logic [CPU_AW:0] wide;
    logic [CPU_AW:0] offset;

    // Range compare and offset computation, one extra bit to avoid wrap.
    always_comb begin
        wide      = {1'b0, addr};
        in_win    = (wide >= LO) && (wide < HI);
        offset    = wide - LO;
        word_addr = offset[FL_AW:1];
        odd       = offset[0];
    end
endmodule

// File: rtl/read_pulse_gen.sv
// Turns the gated request level into a single-cycle read strobe on its rising edge.
// Assumes the processor drops its read enable between distinct requests.
module read_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic pulse
);
    logic hit_q;

    // Remember last cycle's gated request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    assign pulse = hit & ~hit_q;

    // R2: the strobe never lasts more than one cycle.
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/ack_delay_line.sv
// Shift register that carries each issued strobe and its half-select bit
// through LAT stages so that it emerges when the flash data is valid.
// Assumes LAT >= 1; every stage moves every cycle, so requests never merge.
module ack_delay_line #(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_odd,
    output logic out_vld,
    output logic out_odd
);
    logic [LAT-1:0] vld_sr;
    logic [LAT-1:0] odd_sr;

    // First stage captures the newly issued strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr[0] <= 1'b0;
            odd_sr[0] <= 1'b0;
        end else begin
            vld_sr[0] <= in_vld;
            odd_sr[0] <= in_odd;
        end
    end

    genvar g;
    generate
        for (g = 1; g < LAT; g++) begin : g_stage
            // Advance one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_sr[g] <= 1'b0;
                    odd_sr[g] <= 1'b0;
                end else begin
                    vld_sr[g] <= vld_sr[g-1];
                    odd_sr[g] <= odd_sr[g-1];
                end
            end
        end
    endgenerate

    assign out_vld = vld_sr[LAT-1];
    assign out_odd = odd_sr[LAT-1];
endmodule

// File: rtl/flash_fetch_bridge.sv
// Bridges a 16-bit processor fetch port to a 32-bit fixed-latency flash read port.
// Assumes the flash returns data exactly FLASH_LAT cycles after a one-cycle strobe.
module flash_fetch_bridge #(
    parameter int CPU_AW    = 23,
    parameter int ROM_BASE  = 'h4000,
    parameter int ROM_WORDS = 8192,
    parameter int FLASH_LAT = 5,
    parameter int FL_AW     = $clog2(ROM_WORDS) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_en,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_ack,
    output logic              fl_read,
    output logic [FL_AW-1:0]  fl_addr,
    input  logic [31:0]       fl_rdata,
    input  logic              fl_rvalid
);
    import flash_bridge_pkg::*;

    logic in_win;
    logic odd_now;
    logic hit;
    logic odd_out;

    rom_window_decode #(
        .CPU_AW(CPU_AW), .ROM_BASE(ROM_BASE), .ROM_WORDS(ROM_WORDS), .FL_AW(FL_AW)
    ) i_decode (
        .addr(cpu_addr), .in_win(in_win), .word_addr(fl_addr), .odd(odd_now)
    );

    assign hit = cpu_rd_en & in_win;

    read_pulse_gen i_pulse (
        .clk(clk), .rst_n(rst_n), .hit(hit), .pulse(fl_read)
    );

    ack_delay_line #(.LAT(FLASH_LAT)) i_delay (
        .clk(clk), .rst_n(rst_n), .in_vld(fl_read), .in_odd(odd_now),
        .out_vld(cpu_ack), .out_odd(odd_out)
    );

    assign cpu_rdata = pick_half(fl_rdata, odd_out);

    // R1: a strobe needs the processor read enable.
    a_r1_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fl_read |-> cpu_rd_en);

    // R4: the acknowledge lands on the flash data-valid cycle.
    a_r4_ack_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> fl_rvalid);

    // R6: distinct requests never merge into a stretched acknowledge.
    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

// File: tb/test_flash_fetch_bridge.sv
module test_flash_fetch_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 23;
    localparam int BASE  = 'h4000;
    localparam int WORDS = 8192;
    localparam int LAT   = 5;
    localparam int FAW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_rd_en = 1'b0;
    logic [AW-1:0]   cpu_addr = '0;
    logic [15:0]     cpu_rdata;
    logic            cpu_ack;
    logic            fl_read;
    logic [FAW-1:0]  fl_addr;
    logic [31:0]     fl_rdata;
    logic            fl_rvalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_fetch_bridge i_flash_fetch_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .fl_read(fl_read),
        .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_rvalid(fl_rvalid)
    );

    // Flash content as a function of word address.
    function automatic logic [31:0] mem(input logic [FAW-1:0] a);
        return {16'(a * 16'd7 + 16'h1357), 16'(a ^ 16'hA5A5)};
    endfunction

    // Flash model: fixed-latency return, garbage outside the valid cycle.
    logic [LAT-1:0]  fv;
    logic [FAW-1:0]  fa [LAT];
    always_ff @(posedge clk) begin
        if (!rst_n) fv <= '0;
        else        fv <= {fv[LAT-2:0], fl_read};
        fa[0] <= fl_addr;
        for (int i = 1; i < LAT; i++) fa[i] <= fa[i-1];
    end
    assign fl_rvalid = fv[LAT-1];
    assign fl_rdata  = fv[LAT-1] ? mem(fa[LAT-1]) : 32'hBAD0_F00D;

    // Bench reference state.
    logic        exp_ack [LAT];
    logic [15:0] exp_dat [LAT];
    logic        prev_hit;

    function automatic logic in_window(input logic [AW-1:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + WORDS);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_ref();
        for (int i = 0; i < LAT; i++) begin
            exp_ack[i] = 1'b0;
            exp_dat[i] = '0;
        end
        prev_hit = 1'b0;
    endtask

    // One cycle: drive, check combinational and delayed outputs, advance reference.
    task automatic step(input logic rd, input logic [AW-1:0] a, input string ctx);
        logic        hit, rd_exp;
        logic [FAW-1:0] off_w;
        logic        odd;
        int          off;
        @(negedge clk);
        cpu_rd_en = rd;
        cpu_addr  = a;
        #1;
        hit    = rd && in_window(a);
        rd_exp = hit && !prev_hit;
        off    = int'(a) - BASE;
        off_w  = FAW'(off >> 1);
        odd    = off[0];
        check({"R1 R2 R7 strobe ", ctx}, 32'(fl_read), 32'(rd_exp));
        if (rd_exp) check({"R3 flash addr ", ctx}, 32'(fl_addr), 32'(off_w));
        check({"R4 R6 ack ", ctx}, 32'(cpu_ack), 32'(exp_ack[LAT-1]));
        if (exp_ack[LAT-1])
            check({"R5 data ", ctx}, 32'(cpu_rdata), 32'(exp_dat[LAT-1]));
        @(posedge clk);
        for (int i = LAT-1; i > 0; i--) begin
            exp_ack[i] = exp_ack[i-1];
            exp_dat[i] = exp_dat[i-1];
        end
        exp_ack[0] = rd_exp;
        exp_dat[0] = odd ? mem(off_w)[15:0] : mem(off_w)[31:16];
        prev_hit   = hit;
    endtask

    task automatic idle(input int n, input string ctx);
        for (int i = 0; i < n; i++) step(1'b0, '0, ctx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_ref();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset ack", 32'(cpu_ack), 0);
        check("R8 reset strobe", 32'(fl_read), 0);
        rst_n = 1'b1;
        idle(2, "post reset R8");

        // Window edges (R1 R7).
        step(1'b1, AW'(BASE - 1), "below base R7");           idle(7, "R7 drain");
        step(1'b1, AW'(BASE), "base R1");                      idle(7, "R1 drain");
        step(1'b1, AW'(BASE + WORDS - 1), "last word R5");     idle(7, "R5 drain");
        step(1'b1, AW'(BASE + WORDS), "past end R7");          idle(7, "R7 drain");

        // Held enable with wandering address (R2).
        for (int i = 0; i < 10; i++) step(1'b1, AW'(BASE + 40 + i), "held R2");
        idle(7, "R2 drain");

        // Gated edge from moving into the window while held (R2).
        step(1'b1, AW'(BASE - 2), "held outside R2");
        step(1'b1, AW'(BASE + 3), "enter window R2");
        step(1'b1, AW'(BASE + 4), "stay window R2");
        idle(7, "R2 drain");

        // Back-to-back requests in flight (R6).
        for (int i = 0; i < 8; i++) begin
            step(1'b1, AW'(BASE + 100 + i), "pipelined R6");
            step(1'b0, '0, "gap R6");
        end
        idle(7, "R6 drain");

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic rd;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 7)       a = AW'(BASE + int'($urandom_range(0, WORDS - 1)));
            else if (sel == 7) a = AW'(BASE - 1 - int'($urandom_range(0, 3)));
            else if (sel == 8) a = AW'(BASE + WORDS + int'($urandom_range(0, 3)));
            else               a = AW'($urandom);
            rd = ($urandom_range(0, 2) != 0);
            step(rd, a, "random R1 R3 R4 R5 R6");
        end
        idle(8, "final drain");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule